// File: doc/BRIEF.md
# BCD seven-segment latch decoder

This block turns a four-bit binary-coded decimal digit into seven active-high segment drives for a common display glyph. A hold input can freeze the digit. While hold is high, the display keeps showing the last digit that was captured. Two active-low overrides sit after the decoder. The test override lights every segment. The blank override darkens every segment. Neither override changes the captured digit.

The digit is stored in a four-bit register ahead of the decoder, so the design stores the code rather than the decoded glyph. A parameter selects one of two variants:
- **Registered:** the segments change one clock after a new digit is loaded.
- **Flow-through:** while hold is low, the segments track the live input within the same cycle.

In both variants the register loads on every clock edge at which hold is low. Codes 10 through 15 are not valid decimal digits, and they display as dark.

Top module: `bcd_seg_latch_dec`

## Requirements
- R1: While `test_ni` is 0, `seg_o` is 7'b1111111, whatever the values of `blank_ni`, `hold_i` and `digit_i`.
- R2: While `test_ni` is 1 and `blank_ni` is 0, `seg_o` is 7'b0000000.
- R3: With both overrides at 1, the shown digit decodes as follows. Bit 6 of `seg_o` is segment a, bit 0 is segment g, and 1 means lit.
  - 0 → 1111110
  - 1 → 0110000
  - 2 → 1101101
  - 3 → 1111001
  - 4 → 0110011
  - 5 → 1011011
  - 6 → 0011111
  - 7 → 1110000
  - 8 → 1111111
  - 9 → 1110011
- R4: With both overrides at 1, a shown code from 10 to 15 gives `seg_o` = 0.
- R5: While `hold_i` is 1, the stored code does not change, so `seg_o` keeps showing it however `digit_i` moves.
- R6: In the registered variant (`MODE` = `STORE_REG`), a clock edge with `hold_i` at 0 stores `digit_i`. `seg_o` shows the new digit from that edge on, and still shows the previous digit before it.
- R7: In the flow-through variant (`MODE` = `STORE_FLOW`), while `hold_i` is 0, `seg_o` decodes the live `digit_i` in the same cycle.
- R8: Asserting either override does not alter the stored code. Once both overrides are released with `hold_i` at 1, the previously stored digit reappears.
- R9: While `rst_ni` is 0, the stored code is cleared to 0. After reset, with the overrides inactive and hold at 1, `seg_o` shows digit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| digit_i | input | 4 | BCD digit input |
| hold_i | input | 1 | 1 freezes the stored digit, 0 loads it |
| blank_ni | input | 1 | Active-low blanking override |
| test_ni | input | 1 | Active-low lamp-test override, highest priority |
| seg_o | output | 7 | Segments a (bit 6) through g (bit 0), active high |

## Verification
A corrupted stored code appears on `seg_o` as a wrong glyph or an unexpected dark display. This happens on the first sample after the faulty edge, provided both overrides are inactive. While an override is active, the fault stays hidden, and it surfaces on the first sample after the override is released. For that reason the stimulus releases overrides while hold is high. A load that fires on the wrong edge shows up one cycle early or one cycle late, and it is caught by sampling both just before and just after each edge.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_N  = 7;
  localparam int MAX_DIGIT = 9;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_N-1:0]  seg_t;

  typedef enum logic {STORE_REG, STORE_FLOW} store_mode_e;

  localparam seg_t SEG_DARK = '0;
  localparam seg_t SEG_LIT  = '1;
endpackage

// File: rtl/bcd_code_store.sv
module bcd_code_store
  import bcd_seg_pkg::*;
#(
  parameter store_mode_e MODE = STORE_REG
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hold_i,
  input  code_t digit_i,
  output code_t code_q_o,
  output code_t shown_o
);
  code_t code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      code_q <= '0;
    else if (!hold_i) code_q <= digit_i;
  end

  generate
    if (MODE == STORE_FLOW) begin : g_flow
      // bypass the register while it is loading
      assign shown_o = hold_i ? code_q : digit_i;
    end else begin : g_reg
      assign shown_o = code_q;
    end
  endgenerate

  assign code_q_o = code_q;
endmodule

// File: rtl/bcd_seg_rom.sv
module bcd_seg_rom
  import bcd_seg_pkg::*;
(
  input  code_t code_i,
  output seg_t  seg_o
);
  // bit 6 = a ... bit 0 = g
  always_comb begin
    unique case (code_i)
      4'd0:    seg_o = 7'b1111110;
      4'd1:    seg_o = 7'b0110000;
      4'd2:    seg_o = 7'b1101101;
      4'd3:    seg_o = 7'b1111001;
      4'd4:    seg_o = 7'b0110011;
      4'd5:    seg_o = 7'b1011011;
      4'd6:    seg_o = 7'b0011111;
      4'd7:    seg_o = 7'b1110000;
      4'd8:    seg_o = 7'b1111111;
      4'd9:    seg_o = 7'b1110011;
      default: seg_o = SEG_DARK;
    endcase
  end
endmodule

// File: rtl/bcd_seg_override.sv
module bcd_seg_override
  import bcd_seg_pkg::*;
(
  input  logic test_ni,
  input  logic blank_ni,
  input  seg_t raw_i,
  output seg_t seg_o
);
  always_comb begin
    if (!test_ni)       seg_o = SEG_LIT;
    else if (!blank_ni) seg_o = SEG_DARK;
    else                seg_o = raw_i;
  end
endmodule

// File: rtl/bcd_seg_latch_dec.sv
module bcd_seg_latch_dec
  import bcd_seg_pkg::*;
#(
  parameter store_mode_e MODE = STORE_REG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CODE_W-1:0] digit_i,
  input  logic             hold_i,
  input  logic             blank_ni,
  input  logic             test_ni,
  output logic [SEG_N-1:0] seg_o
);
  code_t code_q;
  code_t shown;
  seg_t  raw_seg;

  bcd_code_store #(.MODE(MODE)) store_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (hold_i),
    .digit_i  (digit_i),
    .code_q_o (code_q),
    .shown_o  (shown)
  );

  bcd_seg_rom rom_i (
    .code_i (shown),
    .seg_o  (raw_seg)
  );

  bcd_seg_override ovr_i (
    .test_ni  (test_ni),
    .blank_ni (blank_ni),
    .raw_i    (raw_seg),
    .seg_o    (seg_o)
  );
endmodule

// File: rtl/bcd_seg_latch_dec_chk.sv
module bcd_seg_latch_dec_chk
  import bcd_seg_pkg::*;
(
  input logic  clk_i,
  input logic  rst_ni,
  input code_t digit_i,
  input logic  hold_i,
  input logic  blank_ni,
  input logic  test_ni,
  input seg_t  seg_o,
  input code_t code_q
);
  // R1
  lamp_test_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_ni |-> seg_o == SEG_LIT);

  // R2
  blank_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_ni && !blank_ni) |-> seg_o == SEG_DARK);

  // R4
  illegal_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_ni && blank_ni && hold_i && code_q > 4'd9) |-> seg_o == SEG_DARK);

  // R3
  eight_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_ni && blank_ni && hold_i && code_q == 4'd8) |-> seg_o == SEG_LIT);

  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(code_q));

  // R6
  load_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> code_q == $past(digit_i));
endmodule

bind bcd_seg_latch_dec bcd_seg_latch_dec_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .digit_i  (digit_i),
  .hold_i   (hold_i),
  .blank_ni (blank_ni),
  .test_ni  (test_ni),
  .seg_o    (seg_o),
  .code_q   (code_q)
);

// File: tb/bcd_seg_latch_dec_tb_top.sv
module bcd_seg_latch_dec_tb_top;
  import bcd_seg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] digit = 4'd0;
  logic hold = 1'b1, blank_n = 1'b1, test_n = 1'b1;
  logic [6:0] seg_r, seg_f;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] m_code = 4'd0;

  always #10 clk = ~clk;

  bcd_seg_latch_dec #(.MODE(STORE_REG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .digit_i(digit), .hold_i(hold),
    .blank_ni(blank_n), .test_ni(test_n), .seg_o(seg_r));

  bcd_seg_latch_dec #(.MODE(STORE_FLOW)) dut_f_i (
    .clk_i(clk), .rst_ni(rst_n), .digit_i(digit), .hold_i(hold),
    .blank_ni(blank_n), .test_ni(test_n), .seg_o(seg_f));

  function automatic logic [6:0] glyph(input logic [3:0] c);
    case (c)
      4'd0: return 7'b1111110;
      4'd1: return 7'b0110000;
      4'd2: return 7'b1101101;
      4'd3: return 7'b1111001;
      4'd4: return 7'b0110011;
      4'd5: return 7'b1011011;
      4'd6: return 7'b0011111;
      4'd7: return 7'b1110000;
      4'd8: return 7'b1111111;
      4'd9: return 7'b1110011;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [6:0] expect_seg(input logic t, input logic b,
                                            input logic [3:0] c);
    if (!t) return 7'h7F;
    if (!b) return 7'h00;
    return glyph(c);
  endfunction

  function automatic string tag_of(input logic t, input logic b,
                                   input logic [3:0] c);
    if (!t) return "R1";
    if (!b) return "R2";
    if (c > 4'd9) return "R4";
    return "R3";
  endfunction

  task automatic check(input string tag, input string who,
                       input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, who, act, exp);
    end
  endtask

  // drive after negedge, check both variants, then let the edge happen
  task automatic step(input logic [3:0] d, input logic h,
                      input logic b, input logic t);
    logic [3:0] fc;
    @(negedge clk);
    digit = d; hold = h; blank_n = b; test_n = t;
    #1;
    fc = h ? m_code : d;
    check(tag_of(t, b, m_code), "reg", seg_r, expect_seg(t, b, m_code));
    check(h ? tag_of(t, b, fc) : "R7", "flow", seg_f, expect_seg(t, b, fc));
    @(posedge clk);
    if (!h) m_code = d;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset clears code
    check("R9", "reg reset", seg_r, 7'b1111110);
    check("R9", "flow reset", seg_f, 7'b1111110);
    @(negedge clk);
    rst_n = 1'b1;
    digit = 4'd5;
    #1;
    check("R9", "reg after reset", seg_r, 7'b1111110);

    // sweep all codes and control combinations
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 8; k++)
        step(4'(c), k[0], k[1], k[2]);
    // settle stored code with overrides off for each code
    for (int c = 0; c < 16; c++) begin
      step(4'(c), 1'b0, 1'b1, 1'b1);
      step(4'(c), 1'b1, 1'b1, 1'b1);
    end

    // R6: registered update lands only at the edge
    step(4'd2, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    digit = 4'd3; hold = 1'b0;
    #1;
    check("R6", "reg before edge", seg_r, glyph(4'd2));
    check("R7", "flow same cycle", seg_f, glyph(4'd3));
    @(posedge clk); m_code = 4'd3;
    #1;
    check("R6", "reg after edge", seg_r, glyph(4'd3));

    // R5: hold survives data toggling
    step(4'd7, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      digit = 4'($urandom_range(15)); hold = 1'b1;
      #1;
      check("R5", "reg hold", seg_r, glyph(4'd7));
      check("R5", "flow hold", seg_f, glyph(4'd7));
      @(posedge clk);
    end

    // R8: overrides do not disturb stored code
    step(4'd4, 1'b1, 1'b1, 1'b0);
    step(4'd1, 1'b1, 1'b0, 1'b1);
    step(4'd0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    digit = 4'd9; hold = 1'b1; blank_n = 1'b1; test_n = 1'b1;
    #1;
    check("R8", "reg release", seg_r, glyph(4'd7));
    check("R8", "flow release", seg_f, glyph(4'd7));
    @(posedge clk);

    // constrained random mix, overrides mostly inactive
    for (int i = 0; i < 400; i++)
      step(4'($urandom_range(15)), 1'($urandom_range(1)),
           ($urandom_range(7) != 0), ($urandom_range(7) != 0));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule